// File: doc/BRIEF.md
# Oscillator Frequency Window Monitor

This block supervises an oscillator clock that comes from outside the chip, using a trusted on-chip reference clock as the yardstick. Every 64 reference cycles it takes a fresh count of oscillator edges. The block judges the oscillator healthy only when that count lies between one quarter and four times the window length. In frequency terms, the oscillator must run faster than a quarter of the reference rate and slower than four times the reference rate.

When a measurement falls outside that band, the block raises a sticky fail flag. This flag is bit 0 of the status word. At the same moment the block moves the downstream domain clock from the oscillator to the reference, which then serves as a limp-home clock. Both the flag and the limp selection stay in place until reset, or until software pulses the clear strobe while no new failure is arriving.

The oscillator-domain counter returns its result through a toggle handshake. When the oscillator stops dead, that handshake goes unanswered, and a request left unanswered for a whole window is treated as a low-side failure. The clock switch is glitch-free. One source's enable is withdrawn on that source's falling edge before the other source's enable is granted. When the oscillator has stopped, its enable is forced off.

Top module: `oscwin_monitor`

## Requirements
- R1: With a valid oscillator, `osc_fail` stays 0 after a clear, and `dom_clk` carries the oscillator. A valid oscillator is one whose edge count per 64-cycle reference window lies in 16..256, for example a period between 0.33x and 3x the reference period.
- R2: An oscillator that yields fewer than 16 edges per window (slower than a quarter of the reference rate) sets `osc_fail` to 1.
- R3: An oscillator that yields more than 256 edges per window (faster than four times the reference rate) sets `osc_fail` to 1.
- R4: An oscillator that stops completely sets `osc_fail`, because a measurement request stays unanswered at the end of a window. The flag is therefore set no later than two windows after the stop.
- R5: `osc_fail` is sticky. It stays 1 after the oscillator becomes healthy again, and falls only on reset or on a `stat_clr` pulse in a cycle where no new failure is detected. A new failure in the same cycle wins.
- R6: While `osc_fail` is 1, `dom_clk` follows `ref_clk`, including when the oscillator has stopped. The two source enables are never on together.
- R7: After a clear with a healthy oscillator, `dom_clk` returns to following `osc_clk`.
- R8: After reset, `osc_fail` is 0 and `dom_clk` follows a running oscillator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; also the limp-mode clock |
| osc_clk | input | 1 | External oscillator clock under supervision |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_clr | input | 1 | One-cycle strobe in the ref_clk domain that clears status bit 0 |
| osc_fail | output | 1 | Status bit 0: sticky oscillator-fail flag |
| dom_clk | output | 1 | Domain clock: the oscillator when healthy, the reference in limp mode |

## Verification
On every reference cycle, the assertions check several things. Each low, high or stop event must set the flag on the next cycle. The flag may fall only after a clear strobe. A new measurement request is issued only once the previous one has been answered. The oscillator and reference enables are never both on. Whether an actual oscillator frequency lands on the correct side of the band, how long it takes a stopped clock to be caught, and whether `dom_clk` really tracks the chosen source edge for edge can only be shown by the bench scenarios. Those scenarios use slow, fast, stopped and healthy oscillators, as well as the sticky-then-clear sequence.

// File: rtl/oscwin_pkg.sv
package oscwin_pkg;

  typedef enum logic [1:0] {
    SEL_OSC,
    SEL_DROP_OSC,
    SEL_REF,
    SEL_DROP_REF
  } sel_state_e;

  // count strictly under the lower limit means a slow oscillator
  function automatic logic below_band(input int unsigned cnt, input int unsigned lo);
    return cnt < lo;
  endfunction

  // count strictly over the upper limit means a fast oscillator
  function automatic logic above_band(input int unsigned cnt, input int unsigned hi);
    return cnt > hi;
  endfunction

endpackage

// File: rtl/oscwin_osc_count.sv
module oscwin_osc_count #(
  parameter int CW = 10
) (
  input  logic          osc_clk,
  input  logic          orst_n,
  input  logic          req_tgl,
  output logic          ack_tgl,
  output logic [CW-1:0] hold
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [2:0]    req_s;
  logic [CW-1:0] cnt;

  wire req_edge = req_s[2] ^ req_s[1];

  always_ff @(posedge osc_clk or negedge orst_n) begin
    if (!orst_n) begin
      req_s   <= '0;
      cnt     <= '0;
      hold    <= '0;
      ack_tgl <= 1'b0;
    end else begin
      req_s <= {req_s[1:0], req_tgl};
      if (req_edge) begin
        hold    <= cnt;
        cnt     <= CW'(1);
        ack_tgl <= ~ack_tgl;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_HOLD_QUIET: assert property (@(posedge osc_clk) disable iff (!orst_n)
    !req_edge |=> $stable(hold)) else $error("hold changed without request"); // R1
endmodule

// File: rtl/oscwin_judge.sv
module oscwin_judge import oscwin_pkg::*; #(
  parameter int WIN = 64,
  parameter int LO  = 16,
  parameter int HI  = 256,
  parameter int CW  = 10
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          stat_clr,
  input  logic          ack_tgl,
  input  logic [CW-1:0] hold,
  output logic          req_tgl,
  output logic          fail_q,
  output logic          dead_q
);
  localparam int WW = $clog2(WIN);

  logic [WW-1:0] win_cnt;
  logic [2:0]    ack_s;
  logic          primed;

  wire win_end   = (win_cnt == WW'(WIN - 1));
  wire ack_now   = ack_s[1];
  wire ack_edge  = ack_s[2] ^ ack_s[1];
  wire pending   = req_tgl ^ ack_now;
  wire judge_now = ack_edge & primed;
  wire low_fail  = judge_now & below_band(32'(hold), LO);
  wire high_fail = judge_now & above_band(32'(hold), HI);
  wire stop_fail = win_end & pending;
  wire any_fail  = low_fail | high_fail | stop_fail;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      ack_s   <= '0;
      primed  <= 1'b0;
      req_tgl <= 1'b0;
      fail_q  <= 1'b0;
      dead_q  <= 1'b0;
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + WW'(1);
      ack_s   <= {ack_s[1:0], ack_tgl};
      if (ack_edge) primed <= 1'b1;
      if (win_end && !pending) req_tgl <= ~req_tgl;
      if (any_fail)      fail_q <= 1'b1;
      else if (stat_clr) fail_q <= 1'b0;
      if (stop_fail)     dead_q <= 1'b1;
      else if (stat_clr) dead_q <= 1'b0;
    end
  end

  AST_LOW_SETS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    low_fail |=> fail_q) else $error("low fail not latched"); // R2
  AST_HIGH_SETS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    high_fail |=> fail_q) else $error("high fail not latched"); // R3
  AST_STOP_SETS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stop_fail |=> (fail_q && dead_q)) else $error("stop not latched"); // R4
  AST_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(fail_q) |-> $past(stat_clr)) else $error("flag fell without clear"); // R5
  AST_ONE_REQ: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (req_tgl != $past(req_tgl)) |-> $past(req_tgl == ack_now)) else $error("request overrun"); // R1
endmodule

// File: rtl/oscwin_clk_sel.sv
module oscwin_clk_sel import oscwin_pkg::*; (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic osc_clk,
  input  logic orst_n,
  input  logic use_ref,
  input  logic kill_osc,
  output logic dom_clk
);
  sel_state_e state;
  logic [1:0] osc_chain;
  logic       en_osc;
  logic       en_ref;
  logic [1:0] en_osc_s;

  wire osc_clr_n   = orst_n & ~kill_osc;
  wire osc_want    = (state == SEL_OSC);
  wire osc_seen_on = en_osc_s[1];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEL_OSC;
      en_osc_s <= '0;
    end else begin
      en_osc_s <= {en_osc_s[0], en_osc};
      case (state)
        SEL_OSC:      if (use_ref && (osc_seen_on || kill_osc)) state <= SEL_DROP_OSC;
        SEL_DROP_OSC: if (!osc_seen_on) state <= SEL_REF;
        SEL_REF:      if (!use_ref) state <= SEL_DROP_REF;
        default:      state <= SEL_OSC;
      endcase
    end
  end

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) en_ref <= 1'b0;
    else        en_ref <= (state == SEL_REF);
  end

  always_ff @(posedge osc_clk or negedge osc_clr_n) begin
    if (!osc_clr_n) osc_chain <= '0;
    else            osc_chain <= {osc_chain[0], osc_want};
  end

  always_ff @(negedge osc_clk or negedge osc_clr_n) begin
    if (!osc_clr_n) en_osc <= 1'b0;
    else            en_osc <= osc_chain[1];
  end

  assign dom_clk = (osc_clk & en_osc) | (ref_clk & en_ref);

  AST_EXCL_EN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(en_osc && en_ref)) else $error("both clock enables on"); // R6
  AST_REF_NEEDS_SEL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (state == SEL_REF) |-> $past(use_ref)) else $error("ref chosen unasked"); // R6
endmodule

// File: rtl/oscwin_monitor.sv
module oscwin_monitor #(
  parameter int WIN = 64,
  parameter int LO  = 16,
  parameter int HI  = 256
) (
  input  logic ref_clk,
  input  logic osc_clk,
  input  logic rst_n,
  input  logic stat_clr,
  output logic osc_fail,
  output logic dom_clk
);
  localparam int CW = $clog2(HI) + 2;

  logic [1:0]    orst_q;
  logic          orst_n;
  logic          req_tgl;
  logic          ack_tgl;
  logic [CW-1:0] hold;
  logic          dead_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) orst_q <= '0;
    else        orst_q <= {orst_q[0], 1'b1};
  end
  assign orst_n = orst_q[1];

  oscwin_osc_count #(.CW(CW)) i_count (
    .osc_clk (osc_clk),
    .orst_n  (orst_n),
    .req_tgl (req_tgl),
    .ack_tgl (ack_tgl),
    .hold    (hold)
  );

  oscwin_judge #(.WIN(WIN), .LO(LO), .HI(HI), .CW(CW)) i_judge (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .stat_clr (stat_clr),
    .ack_tgl  (ack_tgl),
    .hold     (hold),
    .req_tgl  (req_tgl),
    .fail_q   (osc_fail),
    .dead_q   (dead_q)
  );

  oscwin_clk_sel i_sel (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .osc_clk  (osc_clk),
    .orst_n   (orst_n),
    .use_ref  (osc_fail),
    .kill_osc (dead_q),
    .dom_clk  (dom_clk)
  );
endmodule

// File: tb/test_oscwin_monitor.sv
`timescale 1ps/1ps
module test_oscwin_monitor;
  localparam int REF_PER = 8000;
  localparam int WIN     = 64;

  logic ref_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic stat_clr = 1'b0;
  logic osc_fail;
  logic dom_clk;
  int   osc_per = 8000;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  oscwin_monitor i_oscwin_monitor (
    .ref_clk  (ref_clk),
    .osc_clk  (osc_clk),
    .rst_n    (rst_n),
    .stat_clr (stat_clr),
    .osc_fail (osc_fail),
    .dom_clk  (dom_clk)
  );

  always #(REF_PER/2) ref_clk = ~ref_clk;

  always begin
    if (osc_per == 0) begin
      osc_clk = 1'b0;
      #1000;
    end else begin
      #(osc_per/2);
      osc_clk = ~osc_clk;
    end
  end

  function automatic logic expect_fail(input int per);
    real c;
    if (per == 0) return 1'b1;
    c = 64.0 * real'(REF_PER) / real'(per);
    return (c < 16.0) || (c > 256.0);
  endfunction

  task automatic wait_win(input int n);
    repeat (n * WIN) @(posedge ref_clk);
  endtask

  task automatic pulse_clr();
    @(negedge ref_clk) stat_clr = 1'b1;
    @(negedge ref_clk) stat_clr = 1'b0;
  endtask

  task automatic check_flag(input logic exp, input string tag);
    #1;
    checks++;
    if (osc_fail !== exp) begin
      fails++;
      $display("FAIL %s osc_fail=%0b expected %0b (osc period %0d ps)", tag, osc_fail, exp, osc_per);
    end
  endtask

  task automatic check_follow(input logic want_ref, input string tag);
    int bad = 0;
    logic act = 1'b0;
    logic exp = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (want_ref) begin
        @(ref_clk); #1;
        if (dom_clk !== ref_clk) begin bad++; act = dom_clk; exp = ref_clk; end
      end else begin
        @(osc_clk); #1;
        if (dom_clk !== osc_clk) begin bad++; act = dom_clk; exp = osc_clk; end
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s dom_clk=%0b expected %0b (source %s, %0d bad samples)",
               tag, act, exp, want_ref ? "ref" : "osc", bad);
    end
  endtask

  task automatic run_case(input int per, input string tag);
    logic exp;
    osc_per = per;
    wait_win(4);
    pulse_clr();
    wait_win(3);
    exp = expect_fail(per);
    check_flag(exp, tag);
    check_follow(exp, exp ? "R6" : "R7");
  endtask

  initial begin
    #(200000 * REF_PER);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(posedge ref_clk);
    @(negedge ref_clk) rst_n = 1'b1;
    repeat (8) @(posedge ref_clk);
    check_flag(1'b0, "R8");
    check_follow(1'b0, "R8");

    run_case(8000, "R1");
    run_case(50000, "R2");
    run_case(1000, "R3");
    run_case(0, "R4");
    run_case(4000, "R1");

    // R5: sticky through recovery, cleared by strobe
    run_case(60000, "R2");
    osc_per = 8000;
    wait_win(3);
    check_flag(1'b1, "R5");
    check_follow(1'b1, "R5");
    pulse_clr();
    wait_win(3);
    check_flag(1'b0, "R5");
    check_follow(1'b0, "R7");

    for (int k = 0; k < 10; k++) begin
      case ($urandom % 4)
        0: run_case(int'($urandom_range(24000, 2600)), "R1");
        1: run_case(int'($urandom_range(64000, 40000)), "R2");
        2: run_case(int'($urandom_range(1500, 1000)), "R3");
        default: run_case(0, "R4");
      endcase
    end
    run_case(12000, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule